// File: doc/BRIEF.md
# Queue Occupancy Overflow/Underflow Monitor

This block watches a queue from the outside. It sees only the queue's push and pop strobes and keeps its own count of how many entries the queue holds. The queue's data is not stored and is not compared. When a strobe pattern would take that count above the configured depth, the block reports an overflow. When it would take the count below zero, the block reports an underflow.

Each push strobe adds `PUSH_W` entries and each pop strobe removes `POP_W` entries. Both widths default to one. A push and a pop in the same cycle are combined into one net change. Reports come out in two forms: a one-cycle pulse for each offending cycle, and a sticky flag that only reset clears. A two-bit code gives the kind of the most recent error. When the enable input is low, the strobes are ignored.

All pins are plain control and status pins. There is no data stream, so there is no valid/ready handshake and no back-pressure. The monitor never stalls the queue it observes.

Top module: `fifo_occ_mon`

## Requirements
- R1: A push strobe adds `PUSH_W` entries to the internal occupancy and a pop strobe removes `POP_W`. The occupancy always stays between 0 and `DEPTH`.
- R2: A cycle whose net change would take the occupancy above `DEPTH` is an overflow. `ovf_pulse` is high for exactly the one cycle after that clock edge.
- R3: A cycle whose net change would take the occupancy below zero is an underflow. `unf_pulse` is high for exactly the one cycle after that clock edge.
- R4: A push and a pop in the same cycle (with the default widths) leave the occupancy unchanged. This holds even at 0 or at `DEPTH`, and such a cycle raises no error.
- R5: Every further offending push while full, and every further offending pop while empty, is reported again as a separate pulse.
- R6: After an overflow the occupancy is clamped at `DEPTH`. After an underflow it is clamped at 0.
- R7: `ovf_sticky` and `unf_sticky` rise together with their first pulse. They stay high until reset.
- R8: `err_code` shows the kind of the most recent error: 2'b00 means none since reset, 2'b01 means overflow, 2'b10 means underflow. It holds its value until the next error or until reset.
- R9: While `en` is low, strobes have no effect. They cause no pulse, no change to the sticky flags or the code, and no change to the occupancy.
- R10: `rst_n` is an asynchronous, active-low reset. It clears the occupancy and all outputs to 0, and no error is reported while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Monitor enable; strobes are ignored while low |
| push | input | 1 | Push strobe of the observed queue |
| pop | input | 1 | Pop strobe of the observed queue |
| ovf_pulse | output | 1 | One-cycle overflow report |
| unf_pulse | output | 1 | One-cycle underflow report |
| ovf_sticky | output | 1 | Overflow seen since reset |
| unf_sticky | output | 1 | Underflow seen since reset |
| err_code | output | 2 | Kind of the most recent error |

## Verification
The occupancy count is not visible at the ports. A wrong count therefore shows up only when it crosses a boundary: an error pulse appears at the wrong time or fails to appear. After reset or after a clamp, the bench fills the queue to exactly `DEPTH` and then drains it to exactly zero. If the count is off by one, the next overflow or underflow pulse comes one strobe early or one strobe late, and this is visible on the cycle right after the edge that decides it. Faults in the sticky flags or the code show up directly on later cycles, after the events that should have set or held them.

// File: rtl/fifo_mon_pkg.sv
package fifo_mon_pkg;
  typedef enum logic [1:0] {
    ERR_NONE = 2'b00,
    ERR_OVF  = 2'b01,
    ERR_UNF  = 2'b10
  } err_code_e;
endpackage

// File: rtl/occ_tracker.sv
module occ_tracker #(
  parameter int DEPTH  = 8,
  parameter int PUSH_W = 1,
  parameter int POP_W  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_act,
  input  logic pop_act,
  output logic ovf_ev,
  output logic unf_ev
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int SW = $clog2(DEPTH + PUSH_W + POP_W + 1) + 1;

  logic [CW-1:0] occ_q;
  logic [SW-1:0] room_need;
  logic [SW-1:0] level_add;
  logic [SW-1:0] level_sub;
  logic [SW-1:0] level_nxt;

  // Occupancy plus incoming entries, and the number of entries requested out.
  always_comb begin
    level_add = SW'(occ_q) + (push_act ? SW'(PUSH_W) : '0);
    level_sub = pop_act ? SW'(POP_W) : '0;
    room_need = SW'(DEPTH) + level_sub;
    ovf_ev    = (level_add > room_need);
    unf_ev    = (level_add < level_sub);
    level_nxt = level_add - level_sub;
  end

  // The count saturates at either end so that later reports stay consistent.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      occ_q <= '0;
    else if (ovf_ev) occ_q <= CW'(DEPTH);
    else if (unf_ev) occ_q <= '0;
    else             occ_q <= CW'(level_nxt);
  end
endmodule

// File: rtl/err_report.sv
module err_report
  import fifo_mon_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ovf_ev,
  input  logic       unf_ev,
  output logic       ovf_pulse,
  output logic       unf_pulse,
  output logic       ovf_sticky,
  output logic       unf_sticky,
  output logic [1:0] err_code
);
  err_code_e code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_pulse  <= 1'b0;
      unf_pulse  <= 1'b0;
      ovf_sticky <= 1'b0;
      unf_sticky <= 1'b0;
      code_q     <= ERR_NONE;
    end else begin
      ovf_pulse <= ovf_ev;
      unf_pulse <= unf_ev;
      if (ovf_ev) begin
        ovf_sticky <= 1'b1;
        code_q     <= ERR_OVF;
      end
      if (unf_ev) begin
        unf_sticky <= 1'b1;
        code_q     <= ERR_UNF;
      end
    end
  end

  assign err_code = code_q;
endmodule

// File: rtl/fifo_occ_mon.sv
module fifo_occ_mon #(
  parameter int DEPTH  = 8,
  parameter int PUSH_W = 1,
  parameter int POP_W  = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       push,
  input  logic       pop,
  output logic       ovf_pulse,
  output logic       unf_pulse,
  output logic       ovf_sticky,
  output logic       unf_sticky,
  output logic [1:0] err_code
);
  logic push_act, pop_act, ovf_ev, unf_ev;

  assign push_act = en & push;
  assign pop_act  = en & pop;

  occ_tracker #(.DEPTH(DEPTH), .PUSH_W(PUSH_W), .POP_W(POP_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .push_act(push_act), .pop_act(pop_act),
    .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  err_report u_rep (
    .clk(clk), .rst_n(rst_n), .ovf_ev(ovf_ev), .unf_ev(unf_ev),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
    .ovf_sticky(ovf_sticky), .unf_sticky(unf_sticky), .err_code(err_code)
  );
endmodule

// File: rtl/fifo_mon_chk.sv
module fifo_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       push,
  input logic       pop,
  input logic       ovf_pulse,
  input logic       unf_pulse,
  input logic       ovf_sticky,
  input logic       unf_sticky,
  input logic [1:0] err_code
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ovf_pulse && unf_pulse)); // R1
  AST_PUSH_NO_UNF: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> !unf_pulse); // R3
  AST_POP_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> !ovf_pulse); // R2
  AST_OVF_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_sticky |=> ovf_sticky); // R7
  AST_UNF_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    unf_sticky |=> unf_sticky); // R7
  AST_OVF_SETS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> ovf_sticky); // R7
  AST_OVF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_pulse |-> (err_code == 2'b01)); // R8
  AST_UNF_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    unf_pulse |-> (err_code == 2'b10)); // R8
  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ovf_pulse && !unf_pulse)); // R9
  AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    err_code != 2'b11); // R8
endmodule

bind fifo_occ_mon fifo_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .push(push), .pop(pop),
  .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
  .ovf_sticky(ovf_sticky), .unf_sticky(unf_sticky), .err_code(err_code)
);

// File: tb/tb_fifo_occ_mon.sv
module tb_fifo_occ_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  // {en, push, pop, expect_ovf, expect_unf}; DEPTH = 8, starting empty
  localparam logic [4:0] VEC [NV] = '{
    5'b10101, // R3 pop when empty
    5'b11100, // R4 push+pop at zero
    5'b11000, 5'b11000, 5'b11000, 5'b11000, // R1 fill
    5'b11000, 5'b11000, 5'b11000, 5'b11000, // R1 fill to DEPTH
    5'b11010, // R2 push when full
    5'b11010, // R5 repeated overflow
    5'b11100, // R4 push+pop at DEPTH
    5'b01000, // R9 disabled push
    5'b10100, 5'b10100, 5'b10100, 5'b10100, // R6 drain from clamped DEPTH
    5'b10100, 5'b10100, 5'b10100, 5'b10100,
    5'b10101, // R6 ninth pop underflows
    5'b10101, // R5 repeated underflow
    5'b00100, // R9 disabled pop
    5'b11000, // R6 count clamped at zero, push ok
    5'b10100  // R6 pop back to zero ok
  };

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, push = 1'b0, pop = 1'b0;
  logic ovf_pulse, unf_pulse, ovf_sticky, unf_sticky;
  logic [1:0] err_code;
  int checks = 0, fails = 0;
  logic e_os = 1'b0, e_us = 1'b0;
  logic [1:0] e_code = 2'b00;

  fifo_occ_mon #(.DEPTH(8), .PUSH_W(1), .POP_W(1)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .push(push), .pop(pop),
    .ovf_pulse(ovf_pulse), .unf_pulse(unf_pulse),
    .ovf_sticky(ovf_sticky), .unf_sticky(unf_sticky), .err_code(err_code)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b (ovf,unf,os,us,code)", req, act, exp);
    end
  endtask

  task automatic step(input logic e, input logic pu, input logic po,
                      input logic eo, input logic eu, input string req);
    @(negedge clk);
    en = e; push = pu; pop = po;
    @(posedge clk);
    #1;
    if (eo) begin e_os = 1'b1; e_code = 2'b01; end
    if (eu) begin e_us = 1'b1; e_code = 2'b10; end
    chk(req, {ovf_pulse, unf_pulse, ovf_sticky, unf_sticky, err_code},
        {eo, eu, e_os, e_us, e_code});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R10 reset state", {ovf_pulse, unf_pulse, ovf_sticky, unf_sticky, err_code}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++)
      step(VEC[i][4], VEC[i][3], VEC[i][2], VEC[i][1], VEC[i][0], $sformatf("R1 vector %0d", i));
    // Mid-run asynchronous reset with offending strobes held
    @(negedge clk);
    en = 1'b1; push = 1'b0; pop = 1'b1; rst_n = 1'b0;
    #1;
    chk("R10 async clear", {ovf_pulse, unf_pulse, ovf_sticky, unf_sticky, err_code}, 6'b0);
    @(posedge clk);
    #1;
    chk("R10 no report in reset", {ovf_pulse, unf_pulse, ovf_sticky, unf_sticky, err_code}, 6'b0);
    @(negedge clk);
    rst_n = 1'b1; pop = 1'b0;
    e_os = 1'b0; e_us = 1'b0; e_code = 2'b00;
    // After reset the count is zero: eight pushes fit, the ninth overflows
    for (int i = 0; i < 8; i++) step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R10 count cleared fill");
    step(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, "R2 overflow after reset");
    step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R2 pulse lasts one cycle");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R7 sticky holds");
    // Empty back to zero, then underflow: code switches to underflow
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, "R6 drain");
    step(1'b1, 1'b0, 1'b1, 1'b0, 1'b1, "R8 code follows latest error");
    step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 disabled both");
    step(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R4 push+pop at zero again");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule